// File: doc/BRIEF.md
# Fenced Store Buffer

This block is a small in-order store buffer placed between the memory stage of a core and the write port of a cache. Stores are accepted into an associative queue and written to the cache in arrival order, one per cycle, whenever the cache signals ready. A load lookup searches the queue, and the youngest buffered store to the same address supplies its data directly. A load that finds no match is passed on to the cache read path and counted as outstanding until its return is signalled.

Ordering is enforced through a fence handshake. A store fence waits until the queue is empty. A load fence waits until no older load is outstanding. A full fence waits for both. While a fence waits, the class of access it orders is held back at issue. A locked (atomic) request first waits like a full fence. It then takes the cache write port alone for the cycle it is performed, flagged as locked, and no store or load is accepted while it is pending. A fence whose condition already holds completes in the cycle it is presented, so a run of fences costs nothing after the first.

Top module: `fence_store_buffer`

## Requirements
- R1: After reset the queue is empty (cache valid low), stores and loads are accepted (stReady and ldReady high), and no load is outstanding.
- R2: Buffered stores appear on the cache write port in the order they were accepted, with address and data unchanged and cLock low. One store leaves on each cycle in which cReady is high, and cValid is low once the queue is empty.
- R3: The queue holds 8 stores. stReady is low while 8 stores are buffered, and a store presented then is not stored.
- R4: A load issued to an address held in the queue returns hit with ldPass low and ldData equal to the data of the most recently accepted matching store.
- R5: A load that matches no buffered store asserts ldPass in its issue cycle and counts as one outstanding load until ldRet is pulsed once for it.
- R6: A store fence (fnKind 01) raises fnReady only in a cycle where the queue is empty. While it is pending, stReady is low.
- R7: A load fence (fnKind 10) raises fnReady only in a cycle where no load is outstanding. While it is pending, ldReady is low.
- R8: A full fence (fnKind 11) raises fnReady only when the queue is empty and no load is outstanding.
- R9: A fence presented while its condition already holds raises fnReady in that same cycle, including each fence of a back-to-back run.
- R10: While atValid is high, stReady and ldReady are low. Once the queue is empty and no load is outstanding, the cache write port carries atAddr/atData with cLock high. atReady is high in the cycle that cReady accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store request present |
| stReady | output | 1 | Store accepted this cycle when valid |
| stAddr | input | 8 | Store address |
| stData | input | 16 | Store data |
| ldValid | input | 1 | Load lookup present |
| ldReady | output | 1 | Load issued this cycle when valid |
| ldAddr | input | 8 | Load address |
| ldData | output | 16 | Forwarded data on a hit |
| ldPass | output | 1 | Issued load missed; send it to the cache read path |
| ldRet | input | 1 | One outstanding load has returned |
| fnValid | input | 1 | Fence present |
| fnKind | input | 2 | 01 store, 10 load, 11 full; 00 never completes |
| fnReady | output | 1 | Fence condition met this cycle |
| atValid | input | 1 | Locked request present |
| atAddr | input | 8 | Locked request address |
| atData | input | 16 | Locked request data |
| atReady | output | 1 | Locked request performed this cycle |
| cValid | output | 1 | Cache write request valid |
| cReady | input | 1 | Cache accepts the write |
| cAddr | output | 8 | Cache write address |
| cData | output | 16 | Cache write data |
| cLock | output | 1 | Current cache write is the locked request |

## Verification
The hardest case to reach is a full fence, or a locked request, with both sides busy at once. The queue must hold stores while loads are still outstanding, and the two sides must then drain at different times. The stimulus fills the queue with the cache stalled and issues misses against it. It then releases the cache and the load returns in separate cycles, and checks that completion waits for the later of the two. The youngest-match rule is driven by filling the queue with repeated addresses, so that every hit has an older shadowed entry.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  // Strobes from control to the storage datapath
  typedef struct packed {
    logic push;
    logic pop;
  } sbfStrobe_t;
endpackage

// File: rtl/sbf_datapath.sv
module sbf_datapath
  import sbf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  sbfStrobe_t    strobe,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] lkAddr,
  output logic [AW-1:0] headAddr,
  output logic [DW-1:0] headData,
  output logic          isEmpty,
  output logic          isFull,
  output logic          lkHit,
  output logic [DW-1:0] lkData
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [AW-1:0] addrMem [DEPTH];
  logic [DW-1:0] dataMem [DEPTH];
  logic [PW-1:0] headPtr, tailPtr;
  logic [CW-1:0] count;

  assign isEmpty  = (count == '0);
  assign isFull   = (count == CW'(DEPTH));
  assign headAddr = addrMem[headPtr];
  assign headData = dataMem[headPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (strobe.push) tailPtr <= tailPtr + 1'b1;
      if (strobe.pop)  headPtr <= headPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrMem[tailPtr] <= wrAddr;
      dataMem[tailPtr] <= wrData;
    end
  end

  // Search oldest to youngest; a later match overrides an earlier one
  always_comb begin
    lkHit  = 1'b0;
    lkData = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] idx;
      idx = headPtr + PW'(k);
      if ((CW'(k) < count) && (addrMem[idx] == lkAddr)) begin
        lkHit  = 1'b1;
        lkData = dataMem[idx];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (count < CW'(DEPTH)) || strobe.pop); // R3
  AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && !strobe.push) |=> count == $past(count) - 1'b1); // R2
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> count != '0); // R2
endmodule

// File: rtl/sbf_control.sv
module sbf_control
  import sbf_pkg::*;
#(
  parameter int LCW = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stValid,
  input  logic       ldValid,
  input  logic       ldRet,
  input  logic       fnValid,
  input  logic [1:0] fnKind,
  input  logic       atValid,
  input  logic       cReady,
  input  logic       isEmpty,
  input  logic       isFull,
  input  logic       lkHit,
  output logic       stReady,
  output logic       ldReady,
  output logic       ldPass,
  output logic       fnReady,
  output logic       atReady,
  output logic       cValid,
  output logic       cLock,
  output sbfStrobe_t strobe
);
  localparam logic [LCW-1:0] LD_MAX = {LCW{1'b1}};

  logic [LCW-1:0] ldOut;
  logic loadsDrained, stBlock, ldBlock, ldIssue, atGo;
  logic needSt, needLd;

  assign loadsDrained = (ldOut == '0);
  assign needSt  = fnKind[0];
  assign needLd  = fnKind[1];
  assign stBlock = (fnValid && needSt) || atValid;
  assign ldBlock = (fnValid && needLd) || atValid;

  assign stReady = !isFull && !stBlock;
  assign ldReady = !ldBlock && (ldOut != LD_MAX);
  assign ldIssue = ldValid && ldReady;
  assign ldPass  = ldIssue && !lkHit;

  assign fnReady = fnValid && (fnKind != 2'b00)
                 && (!needSt || isEmpty) && (!needLd || loadsDrained);

  assign atGo    = atValid && isEmpty && loadsDrained;
  assign cLock   = atGo;
  assign cValid  = !isEmpty || atGo;
  assign atReady = atGo && cReady;

  assign strobe.push = stValid && stReady;
  assign strobe.pop  = !isEmpty && cReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldOut <= '0;
    end else begin
      case ({ldPass, ldRet})
        2'b10:   ldOut <= ldOut + 1'b1;
        2'b01:   ldOut <= ldOut - 1'b1;
        default: ldOut <= ldOut;
      endcase
    end
  end

  AST_LD_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (ldRet && !ldPass) |-> ldOut != '0); // R5
  AST_ST_FENCE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fnValid && fnKind[0]) |-> !strobe.push); // R6
  AST_LD_FENCE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fnValid && fnKind[1]) |-> !ldPass); // R7
  AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    cLock |-> !strobe.pop && !strobe.push && !ldPass); // R10
  AST_FULL_FENCE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (fnReady && fnKind == 2'b11) |=> $past(ldOut) == '0); // R8
endmodule

// File: rtl/fence_store_buffer.sv
module fence_store_buffer
  import sbf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int DEPTH = 8,
  parameter int LCW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stValid,
  output logic          stReady,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic          ldValid,
  output logic          ldReady,
  input  logic [AW-1:0] ldAddr,
  output logic [DW-1:0] ldData,
  output logic          ldPass,
  input  logic          ldRet,
  input  logic          fnValid,
  input  logic [1:0]    fnKind,
  output logic          fnReady,
  input  logic          atValid,
  input  logic [AW-1:0] atAddr,
  input  logic [DW-1:0] atData,
  output logic          atReady,
  output logic          cValid,
  input  logic          cReady,
  output logic [AW-1:0] cAddr,
  output logic [DW-1:0] cData,
  output logic          cLock
);
  sbfStrobe_t strobe;
  logic [AW-1:0] headAddr;
  logic [DW-1:0] headData;
  logic isEmpty, isFull, lkHit;

  sbf_datapath #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrAddr(stAddr), .wrData(stData), .lkAddr(ldAddr),
    .headAddr(headAddr), .headData(headData),
    .isEmpty(isEmpty), .isFull(isFull),
    .lkHit(lkHit), .lkData(ldData)
  );

  sbf_control #(.LCW(LCW)) uCtrl (
    .clk(clk), .rstN(rstN),
    .stValid(stValid), .ldValid(ldValid), .ldRet(ldRet),
    .fnValid(fnValid), .fnKind(fnKind), .atValid(atValid),
    .cReady(cReady), .isEmpty(isEmpty), .isFull(isFull), .lkHit(lkHit),
    .stReady(stReady), .ldReady(ldReady), .ldPass(ldPass),
    .fnReady(fnReady), .atReady(atReady),
    .cValid(cValid), .cLock(cLock), .strobe(strobe)
  );

  assign cAddr = cLock ? atAddr : headAddr;
  assign cData = cLock ? atData : headData;
endmodule

// File: tb/sim_fence_store_buffer.sv
`timescale 1ns/1ps
module sim_fence_store_buffer;
  logic clk = 1'b0;
  logic rstN;
  logic stValid, stReady, ldValid, ldReady, ldPass, ldRet;
  logic fnValid, fnReady, atValid, atReady, cValid, cReady, cLock;
  logic [1:0] fnKind;
  logic [7:0] stAddr, ldAddr, atAddr, cAddr;
  logic [15:0] stData, ldData, atData, cData;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fence_store_buffer u0 (
    .clk(clk), .rstN(rstN),
    .stValid(stValid), .stReady(stReady), .stAddr(stAddr), .stData(stData),
    .ldValid(ldValid), .ldReady(ldReady), .ldAddr(ldAddr), .ldData(ldData),
    .ldPass(ldPass), .ldRet(ldRet),
    .fnValid(fnValid), .fnKind(fnKind), .fnReady(fnReady),
    .atValid(atValid), .atAddr(atAddr), .atData(atData), .atReady(atReady),
    .cValid(cValid), .cReady(cReady), .cAddr(cAddr), .cData(cData), .cLock(cLock)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 0; stValid = 0; ldValid = 0; ldRet = 0; fnValid = 0; fnKind = 0;
    atValid = 0; cReady = 0; stAddr = 0; stData = 0; ldAddr = 0;
    atAddr = 0; atData = 0;
    repeat (3) tick();
    rstN = 1;
    #1;
    chk("R1 stReady", int'(stReady), 1);
    chk("R1 ldReady", int'(ldReady), 1);
    chk("R1 cValid", int'(cValid), 0);
    fnValid = 1; fnKind = 2'b11; #1;
    chk("R1 R9 full fence at reset", int'(fnReady), 1);
    tick(); fnValid = 0;

    // Fill with repeated addresses, cache stalled
    for (int i = 0; i < 8; i++) begin
      stValid = 1; stAddr = 8'(i % 4); stData = 16'(16'h100 + i); #1;
      chk("R3 accept below depth", int'(stReady), 1);
      tick();
    end
    stValid = 1; stAddr = 8'h07; stData = 16'h1FF; #1;
    chk("R3 full stReady", int'(stReady), 0);
    chk("R2 head addr", int'(cAddr), 0);
    tick(); stValid = 0;

    // Lookup sweep: 0..3 hit youngest, 4..7 miss (7 proves rejected store)
    for (int a = 0; a < 8; a++) begin
      ldValid = 1; ldAddr = 8'(a); #1;
      if (a < 4) begin
        chk("R4 hit", int'(ldPass), 0);
        chk("R4 youngest data", int'(ldData), 16'h104 + a);
      end else begin
        chk("R5 miss pass", int'(ldPass), 1);
      end
      tick();
    end
    ldValid = 0;

    // Load fence with 4 outstanding
    fnValid = 1; fnKind = 2'b10; ldValid = 1; ldAddr = 8'h00; #1;
    chk("R7 fence waits", int'(fnReady), 0);
    chk("R7 loads held", int'(ldReady), 0);
    tick();
    for (int r = 0; r < 4; r++) begin
      ldRet = 1; #1;
      chk("R7 still outstanding", int'(fnReady), 0);
      tick();
    end
    ldRet = 0; #1;
    chk("R7 drained", int'(fnReady), 1);
    tick(); fnValid = 0; ldValid = 0;

    // Store fence with full queue, then drain in order
    fnValid = 1; fnKind = 2'b01; stValid = 1; stAddr = 8'h55; stData = 16'hBEEF; #1;
    chk("R6 fence waits", int'(fnReady), 0);
    chk("R6 stores held", int'(stReady), 0);
    cReady = 1;
    for (int i = 0; i < 8; i++) begin
      #1;
      chk("R2 cValid", int'(cValid), 1);
      chk("R2 order addr", int'(cAddr), i % 4);
      chk("R2 order data", int'(cData), 16'h100 + i);
      chk("R2 not locked", int'(cLock), 0);
      tick();
    end
    #1;
    chk("R6 fence done", int'(fnReady), 1);
    chk("R2 empty", int'(cValid), 0);
    tick(); fnValid = 0; stValid = 0; cReady = 0;

    // Full fence: one store and one outstanding load
    stValid = 1; stAddr = 8'h20; stData = 16'h2222; tick(); stValid = 0;
    ldValid = 1; ldAddr = 8'h30; #1;
    chk("R5 miss pass", int'(ldPass), 1);
    tick(); ldValid = 0;
    fnValid = 1; fnKind = 2'b11; #1;
    chk("R8 both busy", int'(fnReady), 0);
    cReady = 1; #1;
    chk("R2 single entry", int'(cAddr), 8'h20);
    tick(); cReady = 0; #1;
    chk("R8 store side empty", int'(cValid), 0);
    chk("R8 load pending", int'(fnReady), 0);
    ldRet = 1; tick(); ldRet = 0; #1;
    chk("R8 done", int'(fnReady), 1);
    tick(); fnValid = 0;

    // Locked request behind two stores
    stValid = 1; stAddr = 8'h40; stData = 16'h4444; tick();
    stAddr = 8'h41; stData = 16'h4545; tick();
    atValid = 1; atAddr = 8'h07; atData = 16'hAAAA;
    stAddr = 8'h99; stData = 16'h0000; ldValid = 1; ldAddr = 8'h40; #1;
    chk("R10 stores held", int'(stReady), 0);
    chk("R10 loads held", int'(ldReady), 0);
    chk("R10 not yet", int'(atReady), 0);
    chk("R10 no lock yet", int'(cLock), 0);
    cReady = 1; tick(); tick(); #1;
    chk("R10 lock", int'(cLock), 1);
    chk("R10 addr", int'(cAddr), 8'h07);
    chk("R10 data", int'(cData), 16'hAAAA);
    chk("R10 performed", int'(atReady), 1);
    tick(); atValid = 0; stValid = 0; ldValid = 0; cReady = 0; #1;
    chk("R10 nothing slipped in", int'(cValid), 0);

    // Back-to-back fences on empty state
    for (int k = 1; k < 4; k++) begin
      fnValid = 1; fnKind = 2'(k); #1;
      chk("R9 immediate", int'(fnReady), 1);
      tick();
    end
    fnValid = 0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule